// File: doc/BRIEF.md
# PLL Safe Reprogramming Sequencer

This block walks a clock PLL from one set of divider settings (reference divider M, feedback divider N, post divider PL) to another without letting the output clock jump or glitch. When only N differs and the PLL is already running, it glides N to the new value through an external ramp controller and touches nothing else. Any other change goes the long way: glide N down to the lowest value that keeps the VCO in range, halve the output through a temporary divide-by-2, park the output on the bypass clock, leave low-power mode if needed, rewrite the divider word with the PLL disabled, re-enable it and wait for lock, return to the VCO, restore divide-by-1 and glide N up to the target.

A second request turns the PLL off: glide down to the minimum-VCO N, select bypass, clear the enable. Requests are taken only while the sequencer is idle; a program request wins over an off request raised in the same cycle. The ramp controller is reached through a start pulse carrying the N to glide to and a done pulse carrying a failure flag; on that done pulse the sequencer takes the requested N into its divider word. All waits use one shared microsecond timer, and every wait lasts STEP_US microseconds.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the divider word holds M=RST_M in bits [MW-1:0], N=RST_N in bits [MW+NW-1:MW] and PL=RST_PL in the bits above; low-power mode is on, enable, lock detect, VCO select and divide-by-2 are off, and done and fail are low.
- R2: A program request with slide allowed, the PLL enabled and unchanged M and PL issues at most one glide (to the target N, none if N is already there), never selects bypass and never clears the enable.
- R3: A program request with slide allowed, the PLL enabled and a changed M or PL first glides N down to nlo(current M) before divide-by-2 is set.
- R4: On the long path divide-by-2 is set at least STEP_US microseconds before the output switches to bypass, and after relock the VCO is selected at least STEP_US microseconds before divide-by-2 is cleared.
- R5: Low-power mode is left before the PLL is enabled; the enable is never high while low-power mode is on, and the enable only rises while bypass is selected.
- R6: M and PL in the divider word only change while the enable is low; the rewrite loads N=nlo(new M) when slide is allowed and the target N otherwise.
- R7: After enabling, lock detect is on and lock is checked LOCK_TIMEOUT/2+1 times, STEP_US microseconds apart; the VCO is selected only after lock was seen, and if none of the checks sees lock the attempt fails.
- R8: After relock N is glided to the target, so a successful program request ends with the divider word equal to the targets, the PLL enabled, the VCO selected and divide-by-1.
- R9: If a slide-allowed attempt fails (glide failure or no lock), the whole sequence is run once more with slide not allowed; done is pulsed once at the end, with fail high only if the last attempt failed.
- R10: An off request glides N to nlo(current M) when slide is allowed and the PLL is enabled, then selects bypass, then clears the enable; a glide failure here does not stop the sequence or raise fail.
- R11: nlo(m) = ceil(m*MIN_VCO_KHZ/REF_KHZ), saturated to the largest N the field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req | input | 1 | Start a program sequence (idle only) |
| off_req | input | 1 | Start an off sequence (idle only) |
| slide_ok | input | 1 | Gliding of N is allowed for this request |
| want_m | input | MW | Target reference divider |
| want_n | input | NW | Target feedback divider |
| want_pl | input | PLW | Target post divider |
| ramp_start | output | 1 | One-cycle pulse asking the ramp controller to glide |
| ramp_n | output | NW | N to glide to, valid with ramp_start |
| ramp_done | input | 1 | Glide finished |
| ramp_fail | input | 1 | Glide timed out, valid with ramp_done |
| lock_in | input | 1 | PLL lock status |
| sel_vco | output | 1 | Output select: 1 VCO, 0 bypass |
| vco_div2 | output | 1 | VCO output divider: 1 divide by 2, 0 divide by 1 |
| iddq | output | 1 | Low-power mode |
| pll_en | output | 1 | PLL enable |
| lckdet_en | output | 1 | Lock-detect enable |
| coeff | output | MW+NW+PLW | Divider word {PL, N, M} |
| done | output | 1 | One-cycle pulse at the end of a request |
| fail | output | 1 | With done: the request failed |

## Verification
The bench builds the block with TICKS_PER_US=3 and LOCK_TIMEOUT=10, so each wait is six cycles and the lock window is six checks; this makes the lock-failure path and its retry finish in a few dozen cycles while still separating every wait from its neighbours. The remaining parameters keep their defaults, so M of 1 to 3 gives distinct nlo values of 84, 167 and 250 and M of 4 reaches the saturation at 255.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_PLAN, S_RAMP_GO, S_RAMP_WAIT,
        S_DIV2, S_DIV2_WAIT, S_BYPASS, S_IDDQ_WAIT,
        S_EN_OFF, S_COEFF, S_EN_ON, S_LOCK_CHK, S_LOCK_WAIT,
        S_VCO_WAIT, S_DIS_BYP, S_DIS_OFF, S_FINISH
    } seq_state_e;

    // why a glide was issued: decides what a glide failure means
    typedef enum logic [1:0] {
        RC_FAST, RC_DOWN, RC_UP, RC_OFF
    } ramp_ctx_e;

    function automatic logic [63:0] ceil_div(input logic [63:0] num, input logic [63:0] den);
        return (num + den - 64'd1) / den;
    endfunction

endpackage

// File: rtl/pll_us_wait.sv
module pll_us_wait #(
    parameter int TICKS_PER_US = 200,
    parameter int STEP_US      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic fire
);
    localparam int LEN = TICKS_PER_US * STEP_US;
    localparam int CW  = $clog2(LEN + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (go) begin
            run <= 1'b1;
            cnt <= CW'(LEN - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign fire = run && (cnt == '0);

    // R4
    wait_single_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !go) |=> !fire);

endmodule

// File: rtl/pll_nlo_calc.sv
module pll_nlo_calc #(
    parameter int MW          = 8,
    parameter int NW          = 8,
    parameter int REF_KHZ     = 12000,
    parameter int MIN_VCO_KHZ = 1000000
) (
    input  logic [MW-1:0] m_in,
    output logic [NW-1:0] n_out
);
    import pll_seq_pkg::*;

    localparam logic [63:0] MAXN = 64'((64'd1 << NW) - 64'd1);

    logic [63:0] q;

    always_comb begin
        q     = ceil_div(64'(m_in) * 64'(MIN_VCO_KHZ), 64'(REF_KHZ));
        n_out = (q > MAXN) ? {NW{1'b1}} : q[NW-1:0];
    end

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
    parameter int MW           = 8,
    parameter int NW           = 8,
    parameter int PLW          = 6,
    parameter int REF_KHZ      = 12000,
    parameter int MIN_VCO_KHZ  = 1000000,
    parameter int TICKS_PER_US = 200,
    parameter int STEP_US      = 2,
    parameter int LOCK_TIMEOUT = 500,
    parameter int RST_M        = 1,
    parameter int RST_N        = 84,
    parameter int RST_PL       = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prog_req,
    input  logic                  off_req,
    input  logic                  slide_ok,
    input  logic [MW-1:0]         want_m,
    input  logic [NW-1:0]         want_n,
    input  logic [PLW-1:0]        want_pl,
    output logic                  ramp_start,
    output logic [NW-1:0]         ramp_n,
    input  logic                  ramp_done,
    input  logic                  ramp_fail,
    input  logic                  lock_in,
    output logic                  sel_vco,
    output logic                  vco_div2,
    output logic                  iddq,
    output logic                  pll_en,
    output logic                  lckdet_en,
    output logic [MW+NW+PLW-1:0]  coeff,
    output logic                  done,
    output logic                  fail
);
    import pll_seq_pkg::*;

    localparam int POLLS = LOCK_TIMEOUT / 2 + 1;
    localparam int PCW   = $clog2(POLLS + 1);

    seq_state_e     st, ret_st;
    ramp_ctx_e      ctx;
    logic           is_off, slide_q, err_q;
    logic [MW-1:0]  tm, cur_m;
    logic [NW-1:0]  tn, cur_n, ramp_tgt, nlo_cur, nlo_tgt;
    logic [PLW-1:0] tpl, cur_pl;
    logic [PCW-1:0] polls;
    logic           wt_go, wt_fire;

    pll_us_wait #(.TICKS_PER_US(TICKS_PER_US), .STEP_US(STEP_US)) u_wait (
        .clk(clk), .rst(rst), .go(wt_go), .fire(wt_fire));

    pll_nlo_calc #(.MW(MW), .NW(NW), .REF_KHZ(REF_KHZ), .MIN_VCO_KHZ(MIN_VCO_KHZ)) u_nlo_cur (
        .m_in(cur_m), .n_out(nlo_cur));

    pll_nlo_calc #(.MW(MW), .NW(NW), .REF_KHZ(REF_KHZ), .MIN_VCO_KHZ(MIN_VCO_KHZ)) u_nlo_tgt (
        .m_in(tm), .n_out(nlo_tgt));

    assign coeff = {cur_pl, cur_n, cur_m};

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            ret_st     <= S_IDLE;
            ctx        <= RC_FAST;
            is_off     <= 1'b0;
            slide_q    <= 1'b0;
            err_q      <= 1'b0;
            tm         <= '0;
            tn         <= '0;
            tpl        <= '0;
            cur_m      <= MW'(RST_M);
            cur_n      <= NW'(RST_N);
            cur_pl     <= PLW'(RST_PL);
            ramp_tgt   <= '0;
            polls      <= '0;
            wt_go      <= 1'b0;
            ramp_start <= 1'b0;
            ramp_n     <= '0;
            sel_vco    <= 1'b0;
            vco_div2   <= 1'b0;
            iddq       <= 1'b1;
            pll_en     <= 1'b0;
            lckdet_en  <= 1'b0;
            done       <= 1'b0;
            fail       <= 1'b0;
        end else begin
            wt_go      <= 1'b0;
            ramp_start <= 1'b0;
            done       <= 1'b0;
            fail       <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (prog_req || off_req) begin
                        is_off  <= !prog_req;
                        slide_q <= slide_ok;
                        err_q   <= 1'b0;
                        tm      <= want_m;
                        tn      <= want_n;
                        tpl     <= want_pl;
                        st      <= S_PLAN;
                    end
                end
                S_PLAN: begin
                    if (is_off) begin
                        if (slide_q && pll_en) begin
                            ramp_tgt <= nlo_cur; ctx <= RC_OFF; ret_st <= S_DIS_BYP; st <= S_RAMP_GO;
                        end else st <= S_DIS_BYP;
                    end else if (slide_q && pll_en && tm == cur_m && tpl == cur_pl) begin
                        ramp_tgt <= tn; ctx <= RC_FAST; ret_st <= S_FINISH; st <= S_RAMP_GO;
                    end else if (slide_q && pll_en) begin
                        ramp_tgt <= nlo_cur; ctx <= RC_DOWN; ret_st <= S_DIV2; st <= S_RAMP_GO;
                    end else st <= S_DIV2;
                end
                S_RAMP_GO: begin
                    if (ramp_tgt == cur_n) st <= ret_st;
                    else begin
                        ramp_start <= 1'b1;
                        ramp_n     <= ramp_tgt;
                        st         <= S_RAMP_WAIT;
                    end
                end
                S_RAMP_WAIT: begin
                    if (ramp_done) begin
                        cur_n <= ramp_tgt;
                        if (ramp_fail && ctx != RC_OFF) begin
                            if (slide_q) begin slide_q <= 1'b0; st <= S_PLAN; end
                            else begin err_q <= 1'b1; st <= S_FINISH; end
                        end else st <= ret_st;
                    end
                end
                S_DIV2: begin
                    vco_div2 <= 1'b1;
                    wt_go    <= 1'b1;
                    st       <= S_DIV2_WAIT;
                end
                S_DIV2_WAIT: if (wt_fire) begin
                    sel_vco <= 1'b0;
                    st      <= S_BYPASS;
                end
                S_BYPASS: begin
                    if (iddq) begin
                        iddq  <= 1'b0;
                        wt_go <= 1'b1;
                        st    <= S_IDDQ_WAIT;
                    end else st <= S_EN_OFF;
                end
                S_IDDQ_WAIT: if (wt_fire) st <= S_EN_OFF;
                S_EN_OFF: begin
                    pll_en <= 1'b0;
                    st     <= S_COEFF;
                end
                S_COEFF: begin
                    cur_m  <= tm;
                    cur_pl <= tpl;
                    cur_n  <= slide_q ? nlo_tgt : tn;
                    st     <= S_EN_ON;
                end
                S_EN_ON: begin
                    pll_en    <= 1'b1;
                    lckdet_en <= 1'b1;
                    polls     <= '0;
                    st        <= S_LOCK_CHK;
                end
                S_LOCK_CHK: begin
                    if (lock_in) begin
                        sel_vco <= 1'b1;
                        wt_go   <= 1'b1;
                        st      <= S_VCO_WAIT;
                    end else if (polls == PCW'(POLLS - 1)) begin
                        if (slide_q) begin slide_q <= 1'b0; st <= S_PLAN; end
                        else begin err_q <= 1'b1; st <= S_FINISH; end
                    end else begin
                        polls <= polls + 1'b1;
                        wt_go <= 1'b1;
                        st    <= S_LOCK_WAIT;
                    end
                end
                S_LOCK_WAIT: if (wt_fire) st <= S_LOCK_CHK;
                S_VCO_WAIT: if (wt_fire) begin
                    vco_div2 <= 1'b0;
                    ramp_tgt <= tn;
                    ctx      <= RC_UP;
                    ret_st   <= S_FINISH;
                    st       <= S_RAMP_GO;
                end
                S_DIS_BYP: begin
                    sel_vco <= 1'b0;
                    st      <= S_DIS_OFF;
                end
                S_DIS_OFF: begin
                    pll_en <= 1'b0;
                    st     <= S_FINISH;
                end
                S_FINISH: begin
                    done <= 1'b1;
                    fail <= err_q;
                    st   <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R5
    en_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
        pll_en |-> !iddq);

    // R5
    en_rise_in_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en) |-> !sel_vco);

    // R6
    mpl_change_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_m != $past(cur_m) || cur_pl != $past(cur_pl)) |-> !pll_en);

    // R7
    vco_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_vco) |-> ($past(lock_in) && pll_en && lckdet_en));

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        polls <= PCW'(POLLS - 1));

    // R9
    fail_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    // R2
    glide_when_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        ramp_start |-> pll_en);

endmodule

// File: tb/pll_reprog_seq_test.sv
module pll_reprog_seq_test;
    localparam int MW = 8, NW = 8, PLW = 6;
    localparam int TPU = 3, STEP = 2, LTO = 10;
    localparam int GAP = TPU * STEP;

    logic clk = 0, rst = 1;
    logic prog_req = 0, off_req = 0, slide_ok = 0;
    logic [MW-1:0] want_m = 0;
    logic [NW-1:0] want_n = 0;
    logic [PLW-1:0] want_pl = 0;
    logic ramp_start, ramp_done = 0, ramp_fail = 0, lock_in = 0;
    logic [NW-1:0] ramp_n;
    logic sel_vco, vco_div2, iddq, pll_en, lckdet_en, done, fail;
    logic [MW+NW+PLW-1:0] coeff;

    always #2.5 clk = ~clk;

    pll_reprog_seq #(.MW(MW), .NW(NW), .PLW(PLW), .TICKS_PER_US(TPU), .STEP_US(STEP),
                     .LOCK_TIMEOUT(LTO)) uut (
        .clk(clk), .rst(rst), .prog_req(prog_req), .off_req(off_req), .slide_ok(slide_ok),
        .want_m(want_m), .want_n(want_n), .want_pl(want_pl),
        .ramp_start(ramp_start), .ramp_n(ramp_n), .ramp_done(ramp_done), .ramp_fail(ramp_fail),
        .lock_in(lock_in), .sel_vco(sel_vco), .vco_div2(vco_div2), .iddq(iddq),
        .pll_en(pll_en), .lckdet_en(lckdet_en), .coeff(coeff), .done(done), .fail(fail));

    int total = 0, bad = 0, cyc = 0;
    int nr = 0, rcnt = 0, lcnt = 0;
    int ramps [8];
    int coeff_at_ramp = 0;
    bit fail_next = 0, lock_ok = 1, in_prog = 0;
    bit got_done = 0, got_fail = 0;
    int sel_falls = 0, en_falls = 0;
    int v_div = 0, v_en = 0, v_mpl = 0;
    int div_cnt = 0, sel_cnt = 0;
    logic p_sel = 0, p_div = 0, p_en = 0;
    logic [MW+NW+PLW-1:0] p_coeff = 0;

    function automatic int nlo(input int m);
        int q = (m * 1000000 + 12000 - 1) / 12000;
        return (q > 255) ? 255 : q;
    endfunction

    function automatic int fm(input logic [MW+NW+PLW-1:0] c); return int'(c[MW-1:0]); endfunction
    function automatic int fn(input logic [MW+NW+PLW-1:0] c); return int'(c[MW+NW-1:MW]); endfunction
    function automatic int fp(input logic [MW+NW+PLW-1:0] c); return int'(c[MW+NW+PLW-1:MW+NW]); endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ramp controller, lock model and monitor
    always @(negedge clk) begin
        cyc++;
        ramp_done = 0; ramp_fail = 0;
        if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) begin ramp_done = 1; ramp_fail = fail_next; fail_next = 0; end
        end
        if (ramp_start) begin
            rcnt = 4;
            if (nr < 8) ramps[nr] = int'(ramp_n);
            if (nr == 0) coeff_at_ramp = fn(coeff);
            nr++;
        end
        if (pll_en && lckdet_en) lcnt++; else lcnt = 0;
        lock_in = lock_ok && (lcnt >= 5);
        if (vco_div2) div_cnt++; else div_cnt = 0;
        if (sel_vco) sel_cnt++; else sel_cnt = 0;
        if (p_sel && !sel_vco) begin
            sel_falls++;
            if (in_prog && (!vco_div2 || div_cnt < GAP)) v_div++;
        end
        if (p_div && !vco_div2 && (!sel_vco || sel_cnt < GAP)) v_div++;
        if (p_en && !pll_en) en_falls++;
        if (!p_en && pll_en && (sel_vco || iddq)) v_en++;
        if ((fm(coeff) != fm(p_coeff) || fp(coeff) != fp(p_coeff)) && (pll_en || p_en)) v_mpl++;
        if (done) begin got_done = 1; got_fail = fail; end
        p_sel = sel_vco; p_div = vco_div2; p_en = pll_en; p_coeff = coeff;
    end

    task automatic run_op(input bit is_prog, input bit sl, input int m, input int n, input int pl);
        int t = 0;
        @(negedge clk);
        want_m = MW'(m); want_n = NW'(n); want_pl = PLW'(pl); slide_ok = sl;
        prog_req = is_prog; off_req = !is_prog; in_prog = is_prog;
        nr = 0; got_done = 0; got_fail = 0; sel_falls = 0; en_falls = 0;
        @(negedge clk);
        prog_req = 0; off_req = 0;
        while (!got_done && t < 5000) begin @(negedge clk); t++; end
        chk(got_done, "R9 done timeout", t, 5000);
    endtask

    // expected glide count for a program request under the model state
    function automatic int exp_ramps(input bit sl, input bit on, input int cm, input int cn,
                                     input int cpl, input int m, input int n, input int pl);
        int r = 0;
        if (sl && on && m == cm && pl == cpl) return (n != cn) ? 1 : 0;
        if (sl && on && nlo(cm) != cn) r++;
        if (sl && n != nlo(m)) r++;
        return r;
    endfunction

    task automatic check_prog_ok(input string req, input int m, input int n, input int pl);
        chk(fm(coeff) == m && fn(coeff) == n && fp(coeff) == pl, req, int'(coeff), (pl << 16) | (n << 8) | m);
        chk(pll_en && sel_vco && !vco_div2 && !iddq && lckdet_en && !got_fail, req,
            {pll_en, sel_vco, vco_div2, iddq, lckdet_en, got_fail}, 6'b110010);
    endtask

    initial begin
        int rs;
        rs = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(fm(coeff) == 1 && fn(coeff) == 84 && fp(coeff) == 1, "R1 coeff", int'(coeff), 'h15401);
        chk(iddq && !pll_en && !lckdet_en && !sel_vco && !vco_div2 && !done && !fail, "R1 ctrl",
            {iddq, pll_en, lckdet_en, sel_vco, vco_div2, done, fail}, 7'b1000000);

        // R6 R8 from off with slide: word written with nlo(M), then glide up
        run_op(1, 1, 1, 150, 2);
        check_prog_ok("R8 first program", 1, 150, 2);
        chk(nr == 1 && ramps[0] == 150 && coeff_at_ramp == 84, "R6 nlo write", coeff_at_ramp, 84);

        // R2 fast path
        run_op(1, 1, 1, 120, 2);
        check_prog_ok("R2 fast result", 1, 120, 2);
        chk(nr == 1 && ramps[0] == 120 && sel_falls == 0 && en_falls == 0, "R2 glide only", nr, 1);

        // R3 long path with slide: down to nlo(1), up to target
        run_op(1, 1, 2, 200, 1);
        check_prog_ok("R8 long result", 2, 200, 1);
        chk(nr == 2 && ramps[0] == 84 && ramps[1] == 200, "R3 down then up", ramps[0], 84);
        chk(sel_falls == 1 && en_falls == 1, "R3 bypass once", sel_falls, 1);

        // R6 no slide: no glides, direct N
        run_op(1, 0, 3, 100, 3);
        check_prog_ok("R6 no slide", 3, 100, 3);
        chk(nr == 0, "R6 no glide", nr, 0);

        // R9 glide failure in fast path, retry without slide succeeds
        fail_next = 1;
        run_op(1, 1, 3, 180, 3);
        check_prog_ok("R9 retry ok", 3, 180, 3);
        chk(nr == 1 && en_falls == 1, "R9 one glide then full", nr, 1);

        // R7 R9 lock never seen: both attempts fail
        lock_ok = 0;
        run_op(1, 1, 1, 150, 1);
        chk(got_fail && !sel_vco && pll_en, "R7 lock fail", {got_fail, sel_vco, pll_en}, 3'b101);
        chk(nr == 1 && ramps[0] == 250, "R11 nlo(3)", ramps[0], 250);
        lock_ok = 1;

        // R3 from bypass but enabled
        run_op(1, 1, 2, 210, 2);
        check_prog_ok("R3 recover", 2, 210, 2);
        chk(nr == 2 && ramps[0] == 84 && ramps[1] == 210, "R3 recover glides", ramps[1], 210);

        // R10 off with slide, glide failure ignored
        fail_next = 1;
        run_op(0, 1, 0, 0, 0);
        chk(nr == 1 && ramps[0] == 167, "R10 glide nlo(2)", ramps[0], 167);
        chk(!pll_en && !sel_vco && !got_fail, "R10 off", {pll_en, sel_vco, got_fail}, 0);

        // R10 off when already off: no glide
        run_op(0, 1, 0, 0, 0);
        chk(nr == 0 && !pll_en, "R10 idle off", nr, 0);

        // R11 saturation from off: M=4
        run_op(1, 1, 4, 255, 1);
        check_prog_ok("R11 saturated", 4, 255, 1);
        chk(nr == 0, "R11 nlo(4)=255 no glide", nr, 0);

        // random programs checked against the model
        for (int i = 0; i < 40; i++) begin
            int m, n, pl, cm, cn, cpl, er;
            bit sl;
            m = 1 + int'($urandom_range(3)); n = 84 + int'($urandom_range(171));
            pl = 1 + int'($urandom_range(5)); sl = 1'($urandom_range(1));
            if (i % 5 == 0) begin m = fm(coeff); pl = fp(coeff); sl = 1; end
            cm = fm(coeff); cn = fn(coeff); cpl = fp(coeff);
            er = exp_ramps(sl, 1'b1, cm, cn, cpl, m, n, pl);
            run_op(1, sl, m, n, pl);
            check_prog_ok("R8 random", m, n, pl);
            chk(nr == er, "R2 R3 random glides", nr, er);
        end

        chk(v_div == 0, "R4 divider timing", v_div, 0);
        chk(v_en == 0, "R5 enable order", v_en, 0);
        chk(v_mpl == 0, "R6 M PL while enabled", v_mpl, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule